// File: doc/BRIEF.md
# Two-Flag Class-Ordered Victim Frame Picker

This block tracks, for every physical frame, whether it has been touched recently and whether its contents have been changed since loading. When the replacement logic needs room, it raises a request and the block names one frame to evict. Each frame falls into one of four classes built from its two flags. The block searches only the best class that currently holds at least one frame. Inside that class it picks a frame pseudo-randomly.

Access strobes carry a frame index and a write qualifier. An access marks the frame as touched. A write access also marks it as changed. A free-running interval timer wipes every touched flag once per period, so that only recent activity counts. The changed flags survive these wipes. Table storage and the transfer of evicted pages are handled elsewhere.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset no frame is touched or changed, so every frame is in class 0, and `victim_valid` is low.
- R2: An access strobe (`acc_valid` high) sets the touched flag of frame `acc_frame`. If `acc_write` is also high, it sets that frame's changed flag as well.
- R3: The class number of a frame is 2×touched + changed. Class 0 is untouched and unchanged, class 1 untouched and changed, class 2 touched and unchanged, class 3 touched and changed. The victim always belongs to the lowest-numbered class that has a member.
- R4: The choice inside a class is pseudo-random. Over 32 back-to-back requests with all frames in one class, at least 4 distinct frames are named.
- R5: Counting from reset release, every `CLEAR_PERIOD`-th clock edge clears all touched flags. Changed flags are never cleared.
- R6: An access strobe on the same edge as the periodic clear leaves the touched flag of its frame set.
- R7: A request with `pick_req` high is answered on the following clock edge. `victim_valid` is high for exactly that one cycle, and `victim_idx` holds the choice. The choice is based on the flags as they stood before any access strobe given in the same cycle as the request.
- R8: `victim_valid` is low in every cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_frame | input | FRAME_BITS | Frame touched by the access |
| acc_write | input | 1 | Access is a write |
| pick_req | input | 1 | Request for a victim |
| victim_idx | output | FRAME_BITS | Chosen frame |
| victim_valid | output | 1 | Victim strobe, one cycle after the request |

## Verification
Two events can fall on the same edge. In the first, an access strobe coincides with the periodic clear of the touched flags. In the second, a victim request coincides with an access strobe. The bench builds the first case from a state in which one frame is the only untouched, unchanged candidate-to-be. It then drives an access to that frame on exactly the clearing edge. A lost access would make that frame the victim afterwards, while a kept access pushes it into class 2. The second case is judged against a bench model that forms the class ranking from the flags as they stood before the strobe.

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int          FRAME_BITS   = 4,
  parameter int          CLEAR_PERIOD = 256,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [FRAME_BITS-1:0] acc_frame,
  input  logic                  acc_write,
  input  logic                  pick_req,
  output logic [FRAME_BITS-1:0] victim_idx,
  output logic                  victim_valid
);
  localparam int NF = 1 << FRAME_BITS;
  localparam int TW = $clog2(CLEAR_PERIOD + 1);

  logic [NF-1:0]         touched, changed;
  logic [TW-1:0]         tmr;
  logic [15:0]           lfsr;
  logic [NF-1:0]         pool, hit;
  logic [FRAME_BITS-1:0] start, pick, idx;
  logic                  tick;

  wire [NF-1:0] c0 = ~touched & ~changed;
  wire [NF-1:0] c1 = ~touched &  changed;
  wire [NF-1:0] c2 =  touched & ~changed;
  wire [NF-1:0] c3 =  touched &  changed;

  assign pool  = (|c0) ? c0 : (|c1) ? c1 : (|c2) ? c2 : c3;
  assign start = lfsr[FRAME_BITS-1:0];
  assign tick  = (tmr == TW'(CLEAR_PERIOD - 1));
  assign hit   = acc_valid ? ({{(NF-1){1'b0}}, 1'b1} << acc_frame) : '0;

  always_comb begin
    pick = start;
    idx  = start;
    for (int k = NF - 1; k >= 0; k--) begin
      idx = start + FRAME_BITS'(k);
      if (pool[idx]) pick = idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      touched      <= '0;
      changed      <= '0;
      tmr          <= '0;
      lfsr         <= LFSR_SEED;
      victim_idx   <= '0;
      victim_valid <= 1'b0;
    end else begin
      touched      <= (tick ? '0 : touched) | hit;
      changed      <= changed | (acc_write ? hit : '0);
      tmr          <= tick ? '0 : tmr + 1'b1;
      lfsr         <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      victim_valid <= pick_req;
      if (pick_req) victim_idx <= pick;
    end
  end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
  parameter int FRAME_BITS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         acc_valid,
  input logic [FRAME_BITS-1:0]        acc_frame,
  input logic                         acc_write,
  input logic                         pick_req,
  input logic [FRAME_BITS-1:0]        victim_idx,
  input logic                         victim_valid,
  input logic [(1<<FRAME_BITS)-1:0]   touched,
  input logic [(1<<FRAME_BITS)-1:0]   changed
);
  localparam int NF = 1 << FRAME_BITS;
  logic [NF-1:0] prev_t, prev_c;
  logic [1:0]    best;

  always_ff @(posedge clk) begin
    prev_t <= touched;
    prev_c <= changed;
  end

  always_comb begin
    best = 2'd3;
    for (int f = 0; f < NF; f++)
      if ({prev_t[f], prev_c[f]} < best) best = {prev_t[f], prev_c[f]};
  end

  a_r7_answer: assert property (@(posedge clk) disable iff (!rst_n)
    pick_req |=> victim_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_req |=> !victim_valid);
  a_r2_touch_set: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> touched[$past(acc_frame)]);
  a_r2_write_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> changed[$past(acc_frame)]);
  a_r5_changed_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((changed & $past(changed)) == $past(changed)));
  a_r3_lowest_class: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> ({prev_t[victim_idx], prev_c[victim_idx]} == best));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
  .acc_write(acc_write), .pick_req(pick_req), .victim_idx(victim_idx),
  .victim_valid(victim_valid), .touched(touched), .changed(changed));

// File: tb/nru_victim_sel_tb.sv
module nru_victim_sel_tb;
  localparam int FB = 4;
  localparam int NF = 16;
  localparam int P  = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, pick_req = 1'b0;
  logic [FB-1:0] acc_frame = '0;
  logic [FB-1:0] victim_idx;
  logic victim_valid;

  int total = 0, bad = 0;

  nru_victim_sel #(.FRAME_BITS(FB), .CLEAR_PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_write(acc_write), .pick_req(pick_req), .victim_idx(victim_idx),
    .victim_valid(victim_valid));

  always #10 clk = ~clk;

  bit m_t[NF], m_c[NF];
  int snap[NF];
  int m_tmr = 0, exp_best = 0;
  bit exp_valid = 0;
  bit win_on = 0;
  bit [NF-1:0] seen = '0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_t[f]) begin m_t[f] = 0; m_c[f] = 0; end
      m_tmr = 0; exp_valid = 0;
    end else begin
      exp_best = 3;
      foreach (m_t[f]) begin
        snap[f] = 2 * m_t[f] + m_c[f];
        if (snap[f] < exp_best) exp_best = snap[f];
      end
      exp_valid = pick_req;
      if (m_tmr == P - 1) begin
        foreach (m_t[f]) m_t[f] = 0;
        m_tmr = 0;
      end else m_tmr++;
      if (acc_valid) begin
        m_t[acc_frame] = 1;
        if (acc_write) m_c[acc_frame] = 1;
      end
    end
  end

  // every-clock comparison against the model (R7, R8, R3)
  always @(negedge clk) if (rst_n) begin
    check(victim_valid === exp_valid, "R7/R8 strobe", victim_valid, exp_valid);
    if (exp_valid && victim_valid === 1'b1) begin
      check(snap[victim_idx] == exp_best, "R3 class", snap[victim_idx], exp_best);
      if (win_on) seen[victim_idx] = 1'b1;
    end
  end

  task automatic cyc(input bit sel, input bit av, input int fr, input bit wr);
    pick_req = sel; acc_valid = av; acc_frame = FB'(fr); acc_write = wr;
    @(negedge clk);
    pick_req = 0; acc_valid = 0; acc_write = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(victim_valid === 1'b0, "R1 reset valid", victim_valid, 0);
        @(negedge clk);
        cyc(1, 0, 0, 0); // R1: first request must land in class 0
        // R4: all frames in class 0, 32 requests
        win_on = 1;
        for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0);
        @(negedge clk);
        win_on = 0;
        check($countones(seen) >= 4, "R4 distinct", $countones(seen), 4);
        // R2 / R3: fill classes step by step, requesting between
        for (int f = 0; f < NF; f++) begin
          if (f != 5) cyc(0, 1, f, 1);
          cyc(1, 0, 0, 0);
        end
        cyc(1, 1, 5, 0);   // R7: request and access together
        cyc(1, 0, 0, 0);
        @(negedge clk);
        check(victim_idx == 4'd5, "R2 only class2 left", victim_idx, 5);
        // R6: access to frame 5 on the clearing edge
        while (m_tmr != P - 1) @(negedge clk);
        cyc(0, 1, 5, 0);
        cyc(1, 0, 0, 0);
        @(negedge clk);
        check(victim_idx != 4'd5, "R6 access kept", victim_idx, 0);
        // R5: one more period with no strobes
        repeat (P + 2) @(negedge clk);
        cyc(1, 0, 0, 0);
        @(negedge clk);
        check(victim_idx == 4'd5, "R5 touched cleared", victim_idx, 5);
        cyc(0, 1, 5, 1);
        cyc(1, 0, 0, 0);
        @(negedge clk);
        check(snap[victim_idx] == 1, "R5 changed kept", snap[victim_idx], 1);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (20000) @(negedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule